// File: doc/BRIEF.md
# Interrupt and Reset Stacking Sequencer

This block takes over the bus from a processor core whenever an exception must be serviced. At each instruction boundary the core pulses a strobe. The sequencer then weighs the pending sources: halt, a non-maskable request, a maskable request, a software interrupt or a wait-for-interrupt instruction. When one of them wins, the sequencer writes the machine state to the stack one byte per cycle. It then reads a 16-bit service address from a fixed vector pair and hands a new program counter and a set-mask pulse back to the core. A reset line that stays high for long enough stops whatever is in progress and fetches the restart vector once the line is released.

While the sequencer owns the bus it raises `core_hold`, and the core must not advance. The core keeps its register values stable on the inputs for the whole sequence. Register updates leave the block as write strobes with their new values.

Top module: `irq_stack_seq`

## Requirements
- R1: Requests are acted on only in a cycle where `insn_end` is high. A pending request alone leaves `core_hold` low.
- R2: The frame is seven write cycles (`vma`=1, `rw`=0) at descending addresses from the latched stack pointer. The bytes go out in this order: PC low, PC high, X low, X high, A, B, CC.
- R3: The cycle after the last push has `vma`=0 and pulses `sp_wr`, with `sp_nxt` equal to the latched stack pointer minus 7.
- R4: The vector is read as two cycles (`vma`=1, `rw`=1), high byte first, at {13'h1FFF, code, 0} and then +1. The codes are IRQ=0 (FFF8), software=1 (FFFA), NMI=2 (FFFC) and reset=3 (FFFE). The following cycle pulses `pc_wr` with {high, low} and pulses `set_i`.
- R5: A low `irq_n` is ignored while `i_mask`=1.
- R6: A non-maskable request is raised by a falling edge of `nmi_n` and ignores `i_mask`. Holding the line low does not raise a second request.
- R7: Priority at a boundary runs halt, then NMI, then unmasked IRQ, then software interrupt, then wait.
- R8: With `halt_n` low at a boundary, the block parks with `ba`=1, `vma`=0 and `rw`=1. Requests that arrive while parked are remembered and serviced when `halt_n` returns high.
- R9: A wait instruction pushes the frame, writes SP, then idles with `ba`=1 and `vma`=0. It leaves for the vector read directly, with no further writes, on an NMI edge or an unmasked IRQ.
- R10: A `cpu_rst` pulse shorter than `RST_MIN` cycles is ignored, and the state in progress continues.
- R11: On the `RST_MIN`-th consecutive high sample of `cpu_rst`, any activity stops at once (`vma`=0, `ba`=0, `core_hold`=1). On release, the block fetches FFFE/FFFF, loads PC and sets the mask.
- R12: After `rst`, the outputs `vma`, `ba`, `core_hold`, `sp_wr` and `pc_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| cpu_rst | input | 1 | Processor reset request, active high, filtered |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| irq_n | input | 1 | Maskable request, active low level |
| halt_n | input | 1 | Halt request, active low |
| i_mask | input | 1 | Current interrupt mask bit |
| insn_end | input | 1 | Instruction boundary strobe |
| swi_req | input | 1 | Boundary is a software interrupt instruction |
| wai_req | input | 1 | Boundary is a wait-for-interrupt instruction |
| pc | input | 16 | Program counter to stack |
| ix | input | 16 | Index register to stack |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| ccr | input | 8 | Condition code byte |
| sp | input | 16 | Stack pointer |
| rdata | input | 8 | Read data for vector fetch |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Bus write data |
| rw | output | 1 | 1 = read, 0 = write |
| vma | output | 1 | Bus cycle valid |
| ba | output | 1 | Bus released (halt or wait) |
| core_hold | output | 1 | Sequencer owns the machine |
| sp_wr | output | 1 | Stack pointer update strobe |
| sp_nxt | output | 16 | New stack pointer |
| pc_wr | output | 1 | Program counter load strobe |
| pc_nxt | output | 16 | Loaded vector |
| set_i | output | 1 | Set interrupt mask strobe |

## Verification
The bench drives the sequence from four kinds of entry: a plain boundary, a parked halt, the wait state and a release from reset. Each entry must lead to its own vector base and its own bus pattern. NMI and IRQ are raised together, once with the mask set and once with it clear. This separates a correct priority from a reversed one and tests the mask gating on each source alone. Holding NMI low across two boundaries separates edge detection from level detection. A reset held one cycle too short in the wait state, and one held long enough in the middle of a push, bracket the hold-time filter exactly at `RST_MIN`.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  // bytes in one saved frame: two wide registers split into bytes plus three narrow ones
  parameter int FRAME_N = 2 * (ADDR_W / DATA_W) + 2 * (ADDR_W / DATA_W) / 2 + 1;

  // code sits in address bits [2:1] of the vector pair
  typedef enum logic [1:0] {
    SRC_IRQ = 2'd0,
    SRC_SWI = 2'd1,
    SRC_NMI = 2'd2,
    SRC_RST = 2'd3
  } src_e;

  typedef enum logic [3:0] {
    ST_RUN, ST_PUSH, ST_GAP, ST_VHI, ST_VLO, ST_LOAD, ST_WAIT, ST_HALT, ST_RHOLD
  } st_e;

  function automatic logic [ADDR_W-1:0] vec_addr(input src_e s, input logic lo);
    vec_addr = {{(ADDR_W-3){1'b1}}, s, lo};
  endfunction
endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
  parameter int MIN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  output logic hit
);
  localparam int CW = $clog2(MIN + 1);
  localparam logic [CW-1:0] TOP = CW'(MIN);
  localparam logic [CW-1:0] EDGE_AT = CW'(MIN - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)           run <= '0;
    else if (!line)    run <= '0;
    else if (run != TOP) run <= run + 1'b1;
  end

  // high on the sample that completes MIN consecutive highs
  assign hit = line && (run == EDGE_AT);
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic clr,
  output logic take
);
  logic prev, pend, fall;

  assign fall = prev & ~nmi_n;
  assign take = pend | fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b1;
      pend <= 1'b0;
    end else begin
      prev <= nmi_n;
      if (clr)       pend <= 1'b0;
      else if (fall) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_mux.sv
module frame_mux #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ix,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  input  logic [DW-1:0] ccr,
  output logic [DW-1:0] byte_o
);
  // slot order is architectural: the return sequence pops in reverse
  always_comb begin
    case (idx)
      IW'(0):  byte_o = pc[DW-1:0];
      IW'(1):  byte_o = pc[AW-1:DW];
      IW'(2):  byte_o = ix[DW-1:0];
      IW'(3):  byte_o = ix[AW-1:DW];
      IW'(4):  byte_o = acc_a;
      IW'(5):  byte_o = acc_b;
      IW'(6):  byte_o = ccr;
      default: byte_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import seq_pkg::*;
#(
  parameter int RST_MIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rst,
  input  logic              nmi_n,
  input  logic              irq_n,
  input  logic              halt_n,
  input  logic              i_mask,
  input  logic              insn_end,
  input  logic              swi_req,
  input  logic              wai_req,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] ix,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  input  logic [DATA_W-1:0] ccr,
  input  logic [ADDR_W-1:0] sp,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rw,
  output logic              vma,
  output logic              ba,
  output logic              core_hold,
  output logic              sp_wr,
  output logic [ADDR_W-1:0] sp_nxt,
  output logic              pc_wr,
  output logic [ADDR_W-1:0] pc_nxt,
  output logic              set_i
);
  localparam int IW = $clog2(FRAME_N);
  localparam logic [IW-1:0] LAST = IW'(FRAME_N - 1);

  st_e               state;
  src_e              src;
  logic [IW-1:0]     idx;
  logic              wai_f, irq_lat;
  logic [ADDR_W-1:0] sp_base;
  logic [DATA_W-1:0] vhi, vlo;
  logic              rst_hit, nmi_take, nmi_clr, irq_ok;
  logic [DATA_W-1:0] push_byte;

  rst_qual #(.MIN(RST_MIN)) u_rq (
    .clk(clk), .rst(rst), .line(cpu_rst), .hit(rst_hit)
  );

  nmi_edge u_ne (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .clr(nmi_clr), .take(nmi_take)
  );

  frame_mux #(.AW(ADDR_W), .DW(DATA_W), .IW(IW)) u_fm (
    .idx(idx), .pc(pc), .ix(ix), .acc_a(acc_a), .acc_b(acc_b), .ccr(ccr),
    .byte_o(push_byte)
  );

  assign irq_ok = (~irq_n | irq_lat) & ~i_mask;

  // pending NMI is consumed wherever it is granted, and dropped by a qualified reset
  always_comb begin
    nmi_clr = rst_hit;
    case (state)
      ST_RUN:  if (insn_end && halt_n && nmi_take) nmi_clr = 1'b1;
      ST_HALT: if (halt_n && nmi_take)             nmi_clr = 1'b1;
      ST_WAIT: if (nmi_take)                       nmi_clr = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      src     <= SRC_IRQ;
      idx     <= '0;
      wai_f   <= 1'b0;
      irq_lat <= 1'b0;
      sp_base <= '0;
      vhi     <= '0;
      vlo     <= '0;
    end else if (rst_hit) begin
      state   <= ST_RHOLD;
      irq_lat <= 1'b0;
      wai_f   <= 1'b0;
    end else begin
      case (state)
        ST_RUN: if (insn_end) begin
          if (!halt_n) state <= ST_HALT;
          else if (nmi_take || irq_ok || swi_req || wai_req) begin
            state   <= ST_PUSH;
            idx     <= '0;
            sp_base <= sp;
            wai_f   <= !nmi_take && !irq_ok && !swi_req;
            src     <= nmi_take ? SRC_NMI : irq_ok ? SRC_IRQ : swi_req ? SRC_SWI : SRC_IRQ;
          end
        end
        ST_PUSH: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= ST_GAP;
        end
        ST_GAP:  state <= wai_f ? ST_WAIT : ST_VHI;
        ST_WAIT: begin
          if (nmi_take) begin
            src <= SRC_NMI; state <= ST_VHI; wai_f <= 1'b0;
          end else if (irq_ok) begin
            src <= SRC_IRQ; state <= ST_VHI; wai_f <= 1'b0;
          end
        end
        ST_VHI: begin
          vhi   <= rdata;
          state <= ST_VLO;
        end
        ST_VLO: begin
          vlo   <= rdata;
          state <= ST_LOAD;
        end
        ST_LOAD: state <= ST_RUN;
        ST_HALT: begin
          if (!irq_n) irq_lat <= 1'b1;
          if (halt_n) begin
            irq_lat <= 1'b0;
            if (nmi_take || irq_ok) begin
              state   <= ST_PUSH;
              idx     <= '0;
              sp_base <= sp;
              wai_f   <= 1'b0;
              src     <= nmi_take ? SRC_NMI : SRC_IRQ;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RHOLD: if (!cpu_rst) begin
          src   <= SRC_RST;
          state <= ST_VHI;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // outputs decode straight from the state flops
  always_comb begin
    vma   = (state == ST_PUSH) || (state == ST_VHI) || (state == ST_VLO);
    rw    = (state != ST_PUSH);
    ba    = (state == ST_WAIT) || (state == ST_HALT);
    core_hold = (state != ST_RUN);
    sp_wr = (state == ST_GAP);
    pc_wr = (state == ST_LOAD);
    set_i = (state == ST_LOAD);
    wdata = (state == ST_PUSH) ? push_byte : '0;
    case (state)
      ST_PUSH: addr = sp_base - {{(ADDR_W-IW){1'b0}}, idx};
      ST_VHI:  addr = vec_addr(src, 1'b0);
      ST_VLO:  addr = vec_addr(src, 1'b1);
      default: addr = '0;
    endcase
  end

  assign sp_nxt = sp_base - ADDR_W'(FRAME_N);
  assign pc_nxt = {vhi, vlo};
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int RST_MIN = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        cpu_rst,
  input logic        vma,
  input logic        rw,
  input logic        ba,
  input logic        core_hold,
  input logic        sp_wr,
  input logic        pc_wr,
  input logic        set_i,
  input logic [15:0] addr
);
  localparam int CW = $clog2(RST_MIN + 1);
  logic [CW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)                          hi_run <= '0;
    else if (!cpu_rst)                hi_run <= '0;
    else if (hi_run != CW'(RST_MIN))  hi_run <= hi_run + 1'b1;
  end

  // R8 / R9: a released bus never carries a cycle
  p_ba_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ba |-> (!vma && rw));

  // R2: consecutive pushes step down by one
  p_push_desc_r2: assert property (@(posedge clk) disable iff (rst)
    (vma && !rw && $past(vma && !rw)) |-> (addr == $past(addr) - 16'd1));

  // R3: the stack pointer update follows the last push
  p_sp_after_push_r3: assert property (@(posedge clk) disable iff (rst)
    sp_wr |-> (!vma && $past(vma && !rw)));

  // R4: high vector byte is followed by the low one
  p_vec_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (vma && rw && !cpu_rst && addr[15:3] == 13'h1FFF && !addr[0])
      |=> (vma && rw && addr == $past(addr) + 16'd1));

  // R4: mask set only together with a vector load
  p_seti_load_r4: assert property (@(posedge clk) disable iff (rst)
    set_i |-> (pc_wr && !vma));

  // R11: a qualified reset silences the bus while it is held
  p_rst_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (hi_run == CW'(RST_MIN)) |-> (!vma && !ba && core_hold));
endmodule

bind irq_stack_seq seq_chk #(.RST_MIN(RST_MIN)) u_chk (
  .clk(clk), .rst(rst), .cpu_rst(cpu_rst), .vma(vma), .rw(rw), .ba(ba),
  .core_hold(core_hold), .sp_wr(sp_wr), .pc_wr(pc_wr), .set_i(set_i), .addr(addr)
);

// File: tb/sim_irq_stack_seq.sv
module sim_irq_stack_seq;
  localparam int RMIN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_rst = 0, nmi_n = 1, irq_n = 1, halt_n = 1, i_mask = 0;
  logic insn_end = 0, swi_req = 0, wai_req = 0;
  logic [15:0] pc = 16'h1234, ix = 16'h5678, sp = 16'h01FF;
  logic [7:0]  acc_a = 8'h9A, acc_b = 8'hBC, ccr = 8'hDE;
  logic [7:0]  rdata;
  logic [15:0] addr, sp_nxt, pc_nxt;
  logic [7:0]  wdata;
  logic rw, vma, ba, core_hold, sp_wr, pc_wr, set_i;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    mem = a[7:0] ^ 8'h3C;
  endfunction
  assign rdata = mem(addr);

  irq_stack_seq #(.RST_MIN(RMIN)) u0 (
    .clk(clk), .rst(rst), .cpu_rst(cpu_rst), .nmi_n(nmi_n), .irq_n(irq_n),
    .halt_n(halt_n), .i_mask(i_mask), .insn_end(insn_end), .swi_req(swi_req),
    .wai_req(wai_req), .pc(pc), .ix(ix), .acc_a(acc_a), .acc_b(acc_b), .ccr(ccr),
    .sp(sp), .rdata(rdata), .addr(addr), .wdata(wdata), .rw(rw), .vma(vma),
    .ba(ba), .core_hold(core_hold), .sp_wr(sp_wr), .sp_nxt(sp_nxt),
    .pc_wr(pc_wr), .pc_nxt(pc_nxt), .set_i(set_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] frame_byte(input int k);
    case (k)
      0: frame_byte = pc[7:0];
      1: frame_byte = pc[15:8];
      2: frame_byte = ix[7:0];
      3: frame_byte = ix[15:8];
      4: frame_byte = acc_a;
      5: frame_byte = acc_b;
      default: frame_byte = ccr;
    endcase
  endfunction

  // entered one step after the trigger edge; checks 7 pushes and the gap
  task automatic expect_push();
    for (int k = 0; k < 7; k++) begin
      chk("R2 push vma/rw", {vma, rw}, 2'b10);
      chk("R2 push addr", addr, sp - 16'(k));
      chk("R2 push byte", wdata, frame_byte(k));
      step();
    end
    chk("R3 gap vma", vma, 1'b0);
    chk("R3 sp_wr", sp_wr, 1'b1);
    chk("R3 sp_nxt", sp_nxt, sp - 16'd7);
    step();
  endtask

  task automatic expect_vec(input logic [15:0] base);
    chk("R4 vec hi cycle", {vma, rw, addr}, {2'b11, base});
    step();
    chk("R4 vec lo cycle", {vma, rw, addr}, {2'b11, base + 16'd1});
    step();
    chk("R4 pc load", {pc_wr, set_i, pc_nxt}, {2'b11, mem(base), mem(base + 16'd1)});
    step();
    chk("R4 back to run", core_hold, 1'b0);
  endtask

  task automatic boundary();
    insn_end = 1;
    step();
    insn_end = 0;
    swi_req = 0;
    wai_req = 0;
  endtask

  task automatic t_reset_state();
    chk("R12 idle after rst", {vma, ba, core_hold, sp_wr, pc_wr}, 5'b0);
  endtask

  task automatic t_irq_basic();
    irq_n = 0;
    i_mask = 0;
    step(); step(); step();
    chk("R1 no boundary no service", core_hold, 1'b0);
    boundary();
    irq_n = 1;
    expect_push();
    expect_vec(16'hFFF8);
  endtask

  task automatic t_mask_and_swi();
    pc = 16'hA0B1; ix = 16'hC2D3; acc_a = 8'h11; acc_b = 8'h22; ccr = 8'hD0; sp = 16'h7F40;
    irq_n = 0;
    i_mask = 1;
    boundary();
    chk("R5 masked irq ignored", {core_hold, vma}, 2'b00);
    swi_req = 1;
    boundary();
    chk("R7 swi beats masked irq", core_hold, 1'b1);
    expect_push();
    expect_vec(16'hFFFA);
    irq_n = 1;
  endtask

  task automatic t_nmi();
    i_mask = 0;
    irq_n = 0;
    nmi_n = 0;
    boundary();
    expect_push();
    expect_vec(16'hFFFC);
    boundary();
    expect_push();
    expect_vec(16'hFFF8);  // R6: held-low NMI gave no second request
    irq_n = 1;
    i_mask = 1;
    boundary();
    chk("R6 level nmi no retrigger", core_hold, 1'b0);
    nmi_n = 1;
    step();
    nmi_n = 0;
    boundary();
    chk("R6 nmi ignores mask", core_hold, 1'b1);
    expect_push();
    expect_vec(16'hFFFC);
    nmi_n = 1;
    step();
  endtask

  task automatic t_halt();
    halt_n = 0;
    i_mask = 0;
    irq_n = 0;
    nmi_n = 1;
    boundary();
    chk("R8 halt over irq", {ba, vma, rw, core_hold}, 4'b1011);
    irq_n = 1;
    nmi_n = 0;
    step();
    chk("R8 still parked", {ba, vma}, 2'b10);
    halt_n = 1;
    step();
    expect_push();
    expect_vec(16'hFFFC);
    nmi_n = 1;
    halt_n = 0;
    boundary();
    irq_n = 0;
    step();
    irq_n = 1;
    step();
    chk("R8 parked after irq blip", ba, 1'b1);
    halt_n = 1;
    step();
    chk("R8 latched irq served", core_hold, 1'b1);
    expect_push();
    expect_vec(16'hFFF8);
  endtask

  task automatic t_wait();
    i_mask = 1;
    wai_req = 1;
    boundary();
    expect_push();
    chk("R9 waiting", {ba, vma, core_hold}, 3'b101);
    irq_n = 0;
    step(); step();
    chk("R9 masked irq keeps wait", ba, 1'b1);
    i_mask = 0;
    step();
    irq_n = 1;
    chk("R9 direct to vector", ba, 1'b0);
    expect_vec(16'hFFF8);
  endtask

  task automatic t_short_reset();
    i_mask = 1;
    wai_req = 1;
    boundary();
    expect_push();
    cpu_rst = 1;
    for (int k = 0; k < RMIN - 1; k++) step();
    cpu_rst = 0;
    chk("R10 short reset during pulse", ba, 1'b1);
    step();
    chk("R10 short reset ignored", {ba, core_hold}, 2'b11);
    nmi_n = 0;
    step();
    expect_vec(16'hFFFC);
    nmi_n = 1;
    step();
  endtask

  task automatic t_long_reset();
    i_mask = 0;
    cpu_rst = 1;
    step(); step();
    irq_n = 0;
    boundary();
    irq_n = 1;
    for (int k = 0; k < RMIN - 3; k++) begin
      chk("R11 push before qualify", vma, 1'b1);
      step();
    end
    chk("R11 abort at qualify", {vma, ba, core_hold}, 3'b001);
    step(); step();
    chk("R11 held quiet", {vma, ba, core_hold}, 3'b001);
    cpu_rst = 0;
    step();
    expect_vec(16'hFFFE);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step(); step();
    rst = 0;
    step();
    t_reset_state();
    t_irq_basic();
    t_mask_and_swi();
    t_nmi();
    t_halt();
    t_wait();
    t_short_reset();
    t_long_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule